// File: doc/BRIEF.md
# Interrupt and Bus-Grant Boundary Sequencer

This block runs next to a processor's instruction sequencer and makes one decision each time an instruction finishes. It can redirect the program counter to the interrupt vector, or it can stop the processor and hand the bus to an external DMA master. It can also do nothing. Requests arrive on three active-low lines: a masked interrupt, a forced (unmaskable) interrupt and a bus request. They are looked at only when an instruction flagged as interruptible completes.

Each request is treated as a level, not as a stored edge. If a request line goes low and then high again before an interruptible instruction finishes, that request is lost. The block also handles three other duties:
- It holds the interrupt-enable flag, which set and clear strobes change.
- It drives the reset value of the program counter while the synchronous master reset is applied.
- It toggles a stopped state on each falling edge of the stop/start input.

The `cpu_go` output tells the instruction sequencer when it may advance.

Top module: `irq_bus_seq`

## Requirements
- R1: While `mstr_rst` is sampled high, the following cycle shows `pc_rst_load`=1 and `pc_rst_addr`=0x1000, with `bus_ack`, `halted`, `vec_take` and `ie_flag` all 0. One cycle after reset is sampled low, `pc_rst_load` is 0 and `pc_rst_addr` is 0.
- R2: A cycle with `ie_set`=1 sets `ie_flag` in the next cycle. A cycle with `ie_clr`=1 clears it, and the clear wins when both strobes are high.
- R3: Suppose a boundary happens, meaning `instr_done`=1 and `instr_intok`=1 while `cpu_go`=1. If at that boundary `irq_mask_n`=0, `ie_flag`=1, `irq_force_n`=1 and `dma_req_n`=1, then the next cycle shows `vec_take`=1 and `vec_addr`=0x1004. In every cycle where `vec_take`=0, `vec_addr` is 0.
- R4: A boundary with `irq_mask_n`=0 but `ie_flag`=0 and no other request gives `vec_take`=0.
- R5: A boundary with `irq_force_n`=0 and `dma_req_n`=1 gives `vec_take`=1 with `vec_addr`=0x1004, whatever the value of `ie_flag`.
- R6: Requests have no effect in two cases: when an instruction completes with `instr_intok`=0, and when a request line goes low and then returns high before any boundary occurs.
- R7: A boundary with `dma_req_n`=0 sets `bus_ack`=1 in the next cycle, whatever the value of `ie_flag`. `bus_ack` then stays 1 for as long as `dma_req_n` remains 0.
- R8: While `bus_ack`=1, a cycle with `dma_req_n` sampled high makes `bus_ack` 0 in the next cycle.
- R9: When a bus request and an interrupt meet at the same boundary, `bus_ack` rises and `vec_take` stays 0. An interrupt line that is still low is then taken at the first boundary after `bus_ack` falls.
- R10: Each falling edge of `stop_n` toggles `halted`, and the change is visible in the next cycle. A rising edge has no effect.
- R11: `cpu_go` is 0 whenever any of `halted`, `bus_ack`, `vec_take` or `pc_rst_load` is 1. While `cpu_go` is 0, an instruction completion is ignored.
- R12: `vec_take` never lasts more than one cycle, and `vec_take` and `bus_ack` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mstr_rst | input | 1 | Synchronous master reset, active high |
| irq_mask_n | input | 1 | Masked interrupt request, active low |
| irq_force_n | input | 1 | Unmaskable interrupt request, active low |
| dma_req_n | input | 1 | Bus request from the DMA master, active low |
| stop_n | input | 1 | Stop/start input; each falling edge toggles the stopped state |
| ie_set | input | 1 | Strobe that sets the interrupt-enable flag |
| ie_clr | input | 1 | Strobe that clears the interrupt-enable flag |
| instr_done | input | 1 | Instruction-complete strobe |
| instr_intok | input | 1 | The completing instruction is interruptible |
| ie_flag | output | 1 | Interrupt-enable flag |
| cpu_go | output | 1 | Instruction sequencer may advance |
| vec_take | output | 1 | One-cycle request to load the interrupt vector |
| vec_addr | output | ADDR_W | Interrupt vector address while `vec_take` is 1, otherwise 0 |
| pc_rst_load | output | 1 | Load the program counter with its reset value |
| pc_rst_addr | output | ADDR_W | Reset address while `pc_rst_load` is 1, otherwise 0 |
| bus_ack | output | 1 | Bus granted to the DMA master |
| halted | output | 1 | Execution stopped by the stop/start input |

## Verification
The assertions assume that every input is already synchronous to `clk`, because the block has no synchronizers. They also assume that `ie_set` and `ie_clr` are plain strobes, and that a completion reported while `cpu_go` is low is simply dropped. The stimulus respects these assumptions by changing every input on the falling clock edge. It holds `instr_done` for one cycle per boundary, except in the back-to-back test, which deliberately keeps it high. It also always releases the request lines before it starts a new scenario, so that no pending level carries over into a check that does not expect it.

// File: rtl/irq_bus_seq_pkg.sv
package irq_bus_seq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_BUS    = 2'd1,
    ACT_FORCED = 2'd2,
    ACT_MASKED = 2'd3
  } seq_act_e;

  // Priority at a boundary: bus grant, then forced interrupt, then masked interrupt.
  function automatic seq_act_e pick_action(
    input logic at_boundary,
    input logic bus_rq,
    input logic force_rq,
    input logic mask_rq,
    input logic ie
  );
    seq_act_e a;
    a = ACT_NONE;
    if (at_boundary) begin
      if (bus_rq)
        a = ACT_BUS;
      else if (force_rq)
        a = ACT_FORCED;
      else if (mask_rq && ie)
        a = ACT_MASKED;
    end
    return a;
  endfunction

  function automatic logic is_vector(input seq_act_e a);
    return (a == ACT_FORCED) || (a == ACT_MASKED);
  endfunction

endpackage

// File: rtl/irq_bus_seq_fall.sv
module irq_bus_seq_fall (
  input  logic clk,
  input  logic rst,
  input  logic line_n,
  output logic fall,
  output logic state
);
  logic prev_q;

  assign fall = prev_q & ~line_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      state  <= 1'b0;
    end else begin
      prev_q <= line_n;
      if (fall)
        state <= ~state;
    end
  end
endmodule

// File: rtl/irq_bus_seq_ieflag.sv
module irq_bus_seq_ieflag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (clr_i)
      flag <= 1'b0;
    else if (set_i)
      flag <= 1'b1;
  end
endmodule

// File: rtl/irq_bus_seq_arb.sv
module irq_bus_seq_arb
  import irq_bus_seq_pkg::*;
(
  input  logic     at_boundary,
  input  logic     bus_rq,
  input  logic     force_rq,
  input  logic     mask_rq,
  input  logic     ie,
  output seq_act_e act
);
  always_comb act = pick_action(at_boundary, bus_rq, force_rq, mask_rq, ie);
endmodule

// File: rtl/irq_bus_seq.sv
module irq_bus_seq
  import irq_bus_seq_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'h1000,
  parameter logic [ADDR_W-1:0] INT_VEC   = 16'h1004
) (
  input  logic              clk,
  input  logic              mstr_rst,
  input  logic              irq_mask_n,
  input  logic              irq_force_n,
  input  logic              dma_req_n,
  input  logic              stop_n,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              instr_done,
  input  logic              instr_intok,
  output logic              ie_flag,
  output logic              cpu_go,
  output logic              vec_take,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              pc_rst_load,
  output logic [ADDR_W-1:0] pc_rst_addr,
  output logic              bus_ack,
  output logic              halted
);
  // Named internal events, brought out for the checker.
  logic     boundary;
  logic     stop_fall;
  logic     take_now;
  logic     grant_start;
  logic     grant_end;
  seq_act_e act;

  assign cpu_go   = ~(pc_rst_load | bus_ack | halted | vec_take);
  assign boundary = instr_done & instr_intok & cpu_go;

  irq_bus_seq_fall u_stop (
    .clk    (clk),
    .rst    (mstr_rst),
    .line_n (stop_n),
    .fall   (stop_fall),
    .state  (halted)
  );

  irq_bus_seq_ieflag u_ie (
    .clk   (clk),
    .rst   (mstr_rst),
    .set_i (ie_set),
    .clr_i (ie_clr),
    .flag  (ie_flag)
  );

  irq_bus_seq_arb u_arb (
    .at_boundary (boundary),
    .bus_rq      (~dma_req_n),
    .force_rq    (~irq_force_n),
    .mask_rq     (~irq_mask_n),
    .ie          (ie_flag),
    .act         (act)
  );

  assign take_now    = is_vector(act);
  assign grant_start = (act == ACT_BUS);
  assign grant_end   = bus_ack & dma_req_n;

  always_ff @(posedge clk) begin
    if (mstr_rst) begin
      pc_rst_load <= 1'b1;
      pc_rst_addr <= RESET_VEC;
      vec_take    <= 1'b0;
      vec_addr    <= '0;
      bus_ack     <= 1'b0;
    end else begin
      pc_rst_load <= 1'b0;
      pc_rst_addr <= '0;
      vec_take    <= take_now;
      vec_addr    <= take_now ? INT_VEC : '0;
      if (grant_start)
        bus_ack <= 1'b1;
      else if (grant_end)
        bus_ack <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_bus_seq_chk.sv
module irq_bus_seq_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'h1000,
  parameter logic [ADDR_W-1:0] INT_VEC   = 16'h1004
) (
  input logic              clk,
  input logic              mstr_rst,
  input logic              irq_mask_n,
  input logic              irq_force_n,
  input logic              dma_req_n,
  input logic              ie_set,
  input logic              ie_clr,
  input logic              instr_done,
  input logic              instr_intok,
  input logic              ie_flag,
  input logic              vec_take,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              pc_rst_load,
  input logic [ADDR_W-1:0] pc_rst_addr,
  input logic              bus_ack,
  input logic              halted,
  input logic              boundary,
  input logic              stop_fall
);
  assert_reset_load_R1: assert property (@(posedge clk)
    mstr_rst |=> pc_rst_load && pc_rst_addr == RESET_VEC && !bus_ack && !vec_take);

  assert_ie_set_R2: assert property (@(posedge clk) disable iff (mstr_rst)
    ie_set && !ie_clr |=> ie_flag);

  assert_ie_clr_R2: assert property (@(posedge clk) disable iff (mstr_rst)
    ie_clr |=> !ie_flag);

  assert_masked_take_R3: assert property (@(posedge clk) disable iff (mstr_rst)
    boundary && !irq_mask_n && ie_flag && dma_req_n |=> vec_take);

  assert_vec_addr_R3: assert property (@(posedge clk) disable iff (mstr_rst)
    vec_take |-> vec_addr == INT_VEC);

  assert_masked_off_R4: assert property (@(posedge clk) disable iff (mstr_rst)
    boundary && irq_force_n && !ie_flag |=> !vec_take);

  assert_forced_take_R5: assert property (@(posedge clk) disable iff (mstr_rst)
    boundary && !irq_force_n && dma_req_n |=> vec_take);

  assert_nonint_idle_R6: assert property (@(posedge clk) disable iff (mstr_rst)
    instr_done && !instr_intok && !bus_ack |=> !vec_take && !bus_ack);

  assert_bus_hold_R7: assert property (@(posedge clk) disable iff (mstr_rst)
    bus_ack && !dma_req_n |=> bus_ack);

  assert_bus_release_R8: assert property (@(posedge clk) disable iff (mstr_rst)
    bus_ack && dma_req_n |=> !bus_ack);

  assert_bus_first_R9: assert property (@(posedge clk) disable iff (mstr_rst)
    boundary && !dma_req_n |=> bus_ack && !vec_take);

  assert_stop_toggle_R10: assert property (@(posedge clk) disable iff (mstr_rst)
    stop_fall |=> halted != $past(halted));

  assert_take_pulse_R12: assert property (@(posedge clk) disable iff (mstr_rst)
    vec_take |=> !vec_take);

  assert_take_ack_excl_R12: assert property (@(posedge clk) disable iff (mstr_rst)
    !(vec_take && bus_ack));
endmodule

bind irq_bus_seq irq_bus_seq_chk #(
  .ADDR_W    (ADDR_W),
  .RESET_VEC (RESET_VEC),
  .INT_VEC   (INT_VEC)
) u_chk (
  .clk         (clk),
  .mstr_rst    (mstr_rst),
  .irq_mask_n  (irq_mask_n),
  .irq_force_n (irq_force_n),
  .dma_req_n   (dma_req_n),
  .ie_set      (ie_set),
  .ie_clr      (ie_clr),
  .instr_done  (instr_done),
  .instr_intok (instr_intok),
  .ie_flag     (ie_flag),
  .vec_take    (vec_take),
  .vec_addr    (vec_addr),
  .pc_rst_load (pc_rst_load),
  .pc_rst_addr (pc_rst_addr),
  .bus_ack     (bus_ack),
  .halted      (halted),
  .boundary    (boundary),
  .stop_fall   (stop_fall)
);

// File: tb/tb_irq_bus_seq.sv
module tb_irq_bus_seq;
  localparam int ADDR_W = 16;
  localparam logic [15:0] RST_A = 16'h1000;
  localparam logic [15:0] INT_A = 16'h1004;

  logic clk = 1'b0;
  logic mstr_rst = 1'b1;
  logic irq_mask_n = 1'b1, irq_force_n = 1'b1, dma_req_n = 1'b1, stop_n = 1'b1;
  logic ie_set = 1'b0, ie_clr = 1'b0, instr_done = 1'b0, instr_intok = 1'b0;
  logic ie_flag, cpu_go, vec_take, pc_rst_load, bus_ack, halted;
  logic [ADDR_W-1:0] vec_addr, pc_rst_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_bus_seq dut (
    .clk(clk), .mstr_rst(mstr_rst), .irq_mask_n(irq_mask_n), .irq_force_n(irq_force_n),
    .dma_req_n(dma_req_n), .stop_n(stop_n), .ie_set(ie_set), .ie_clr(ie_clr),
    .instr_done(instr_done), .instr_intok(instr_intok), .ie_flag(ie_flag),
    .cpu_go(cpu_go), .vec_take(vec_take), .vec_addr(vec_addr),
    .pc_rst_load(pc_rst_load), .pc_rst_addr(pc_rst_addr), .bus_ack(bus_ack),
    .halted(halted)
  );

  // Vector fields: [6]ie [5]mask_n [4]force_n [3]dma_n [2]intok [1]exp_take [0]exp_ack
  localparam int NV = 10;
  localparam logic [6:0] VECS [NV] = '{
    7'b1_0_1_1_1_1_0, 7'b0_0_1_1_1_0_0, 7'b0_1_0_1_1_1_0, 7'b1_1_0_1_1_1_0,
    7'b1_0_0_1_0_0_0, 7'b0_1_1_0_1_0_1, 7'b1_0_1_0_1_0_1, 7'b1_1_1_1_1_0_0,
    7'b0_1_1_0_0_0_0, 7'b1_0_0_0_1_0_1
  };
  localparam string TAGS [NV] = '{
    "R3", "R4", "R5", "R5", "R6", "R7", "R9", "R3", "R6", "R9"
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_ie(input logic val);
    ie_set = val;
    ie_clr = ~val;
    @(negedge clk);
    ie_set = 1'b0;
    ie_clr = 1'b0;
  endtask

  task automatic boundary_pulse(input logic ok);
    instr_done  = 1'b1;
    instr_intok = ok;
    @(negedge clk);
    instr_done  = 1'b0;
    instr_intok = 1'b0;
  endtask

  task automatic idle_lines();
    irq_mask_n = 1'b1;
    irq_force_n = 1'b1;
    dma_req_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [6:0] v;
    @(negedge clk);
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 pc_rst_load", pc_rst_load, 1);
    chk("R1 pc_rst_addr", pc_rst_addr, RST_A);
    chk("R1 bus_ack", bus_ack, 0);
    chk("R1 halted", halted, 0);
    chk("R1 vec_take", vec_take, 0);
    chk("R1 ie_flag", ie_flag, 0);
    chk("R11 cpu_go in reset", cpu_go, 0);
    mstr_rst = 1'b0;
    @(negedge clk);
    chk("R1 pc_rst_load after release", pc_rst_load, 0);
    chk("R1 pc_rst_addr after release", pc_rst_addr, 0);
    chk("R11 cpu_go after release", cpu_go, 1);

    // R2 flag strobes
    set_ie(1'b1);
    chk("R2 set", ie_flag, 1);
    ie_set = 1'b1; ie_clr = 1'b1;
    @(negedge clk);
    ie_set = 1'b0; ie_clr = 1'b0;
    chk("R2 clear wins", ie_flag, 0);

    // Table of boundary decisions
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      set_ie(v[6]);
      irq_mask_n = v[5];
      irq_force_n = v[4];
      dma_req_n = v[3];
      boundary_pulse(v[2]);
      chk({TAGS[i], " vec_take"}, vec_take, v[1]);
      chk({TAGS[i], " bus_ack"}, bus_ack, v[0]);
      chk({TAGS[i], " vec_addr"}, vec_addr, v[1] ? INT_A : 16'h0);
      idle_lines();
    end

    // R6 missed window
    set_ie(1'b0);
    irq_force_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 no boundary no take", vec_take, 0);
    irq_force_n = 1'b1;
    @(negedge clk);
    boundary_pulse(1'b1);
    chk("R6 window closed", vec_take, 0);

    // R7 / R8 / R11 bus grant
    dma_req_n = 1'b0;
    boundary_pulse(1'b1);
    chk("R7 bus_ack rise", bus_ack, 1);
    repeat (3) @(negedge clk);
    chk("R7 bus_ack held", bus_ack, 1);
    chk("R11 cpu_go during grant", cpu_go, 0);
    irq_force_n = 1'b0;
    boundary_pulse(1'b1);
    chk("R11 boundary ignored during grant", vec_take, 0);
    irq_force_n = 1'b1;
    dma_req_n = 1'b1;
    @(negedge clk);
    chk("R8 bus_ack drop", bus_ack, 0);
    chk("R8 cpu_go resumes", cpu_go, 1);

    // R9 bus first, interrupt later
    irq_force_n = 1'b0;
    dma_req_n = 1'b0;
    boundary_pulse(1'b1);
    chk("R9 ack wins", bus_ack, 1);
    chk("R9 no take", vec_take, 0);
    dma_req_n = 1'b1;
    @(negedge clk);
    chk("R9 released", bus_ack, 0);
    boundary_pulse(1'b1);
    chk("R9 pending taken", vec_take, 1);
    chk("R9 vec_addr", vec_addr, INT_A);
    idle_lines();

    // R12 back-to-back completions
    irq_force_n = 1'b0;
    instr_done = 1'b1; instr_intok = 1'b1;
    @(negedge clk);
    chk("R12 first take", vec_take, 1);
    @(negedge clk);
    chk("R12 single pulse", vec_take, 0);
    @(negedge clk);
    chk("R12 next take", vec_take, 1);
    instr_done = 1'b0; instr_intok = 1'b0;
    idle_lines();

    // R10 stop/start
    stop_n = 1'b0;
    @(negedge clk);
    chk("R10 stop", halted, 1);
    stop_n = 1'b1;
    @(negedge clk);
    chk("R10 rising ignored", halted, 1);
    irq_force_n = 1'b0;
    boundary_pulse(1'b1);
    chk("R11 boundary ignored while halted", vec_take, 0);
    irq_force_n = 1'b1;
    stop_n = 1'b0;
    @(negedge clk);
    chk("R10 start", halted, 0);
    stop_n = 1'b1;
    @(negedge clk);

    // R1 reset mid-run
    set_ie(1'b1);
    dma_req_n = 1'b0;
    boundary_pulse(1'b1);
    mstr_rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears ack", bus_ack, 0);
    chk("R1 reset clears ie", ie_flag, 0);
    chk("R1 reset load", pc_rst_addr, RST_A);
    dma_req_n = 1'b1;
    mstr_rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule